// File: doc/BRIEF.md
# Voltage-Step Mode Override Controller

This block sits in the digital control section of a step-down regulator and chooses, on every clock, whether the power stage runs in fixed-frequency switching (PWM) or in light-load pulse-skipping (PFM). In normal operation the choice follows a mode configuration field and an external clock-lock request. When the output-voltage select line drops from high to low, the output has to fall to a lower target. For that interval the block overrides every mode request and forces PFM. It also raises two gates: one that blocks reverse inductor current and one that holds off the PFM minimum-frequency control.

The override ends when a comparator reports that the lower target has been reached. It also ends if the select line goes high again before that report arrives. The select line and the comparator flag arrive asynchronously, so each passes through a two-flop synchronizer before any edge or level is used. The mode field and the clock-lock request are quasi-static configuration and are used directly. All outputs are registered.

Top module: `vstep_mode_ctl`

## Requirements
- R1: While reset is high, and in the first cycle after it, all three outputs are 0 (PFM, no reverse-current block, no minimum-frequency hold).
- R2: With no override active, `pwm_o` is 1 one clock after `clk_lock_req_i` is 1 or `mode_cfg_i` equals 2'b01 (forced PWM). Otherwise it is 0, and both gates stay 0.
- R3: A high-to-low change of `level_sel_i` starts an override. The fourth rising clock edge after the change drives `pwm_o` to 0 whatever `clk_lock_req_i` and `mode_cfg_i` hold, and the third edge does not yet do so.
- R4: `rev_block_o` is 1 in exactly the cycles in which the override shows on the outputs.
- R5: `mf_hold_o` is 1 in exactly the cycles in which the override shows on the outputs.
- R6: A 1 on `target_hit_i` during an override ends it. On the fourth rising edge after the flag rises, the outputs return to the R2 behaviour.
- R7: A low-to-high change of `level_sel_i` outside an override starts nothing. The outputs keep following R2.
- R8: A low-to-high change of `level_sel_i` during an override ends it. The outputs return to R2 on the fourth rising edge after the change.
- R9: Changes of `mode_cfg_i` and `clk_lock_req_i` during an override have no effect on the outputs. Once the override ends, their current values apply.
- R10: If `target_hit_i` is already 1 when the select line falls, the override shows on the outputs for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| level_sel_i | input | 1 | Output-voltage select level (1 = upper target, 0 = lower target), asynchronous |
| clk_lock_req_i | input | 1 | External clock-lock request; asks for PWM |
| mode_cfg_i | input | 2 | Mode configuration; 2'b01 forces PWM, other codes allow automatic PFM |
| target_hit_i | input | 1 | Comparator flag: output has reached the new target, asynchronous |
| pwm_o | output | 1 | Selected mode: 1 = PWM, 0 = PFM |
| rev_block_o | output | 1 | Reverse inductor current block enable |
| mf_hold_o | output | 1 | Inhibit for PFM minimum-frequency control |

## Verification
The hardest situations to reach are those in which the override ends without the comparator: a select line that rises again mid-transition, and a comparator flag that is already high when the fall arrives. The bench produces both by driving the raw select and flag pins in a fixed order across the synchronizer latency. It samples one cycle before and exactly at the fourth edge, so the cycle in which the override takes hold is pinned down rather than just eventually observed. During an override it also flips the mode field and clock-lock request to values that would select PWM. It checks that they stay masked and then take effect as soon as the override ends.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_FORCE_PWM = 2'b01;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        ST_NORMAL   = 1'b0,
        ST_STEPDOWN = 1'b1
    } step_state_e;

    typedef struct packed {
        logic pwm;
        logic rev_block;
        logic mf_hold;
    } drive_t;

    localparam drive_t DRIVE_RESET = '{pwm: 1'b0, rev_block: 1'b0, mf_hold: 1'b0};
    localparam drive_t DRIVE_STEP  = '{pwm: 1'b0, rev_block: 1'b1, mf_hold: 1'b1};

    function automatic logic wants_pwm(input logic [MODE_W-1:0] cfg, input logic lock_req);
        return lock_req || (cfg == MODE_FORCE_PWM);
    endfunction

endpackage

// File: rtl/vsm_sync.sv
module vsm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_i;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/vsm_step_fsm.sv
module vsm_step_fsm
    import vsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_s_i,
    input  logic hit_s_i,
    output logic step_o
);
    step_state_e state_q, state_d;
    logic        sel_d;
    logic        fall, rise;

    assign fall = sel_d & ~sel_s_i;
    assign rise = ~sel_d & sel_s_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL:   if (fall) state_d = ST_STEPDOWN;
            ST_STEPDOWN: if (rise || hit_s_i) state_d = ST_NORMAL;
            default:     state_d = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_NORMAL;
            sel_d   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_d   <= sel_s_i;
        end
    end

    assign step_o = (state_q == ST_STEPDOWN);

    p_fall_starts_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORMAL && fall) |=> (state_q == ST_STEPDOWN));
    p_rise_no_start_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORMAL && !fall) |=> (state_q == ST_NORMAL));
    p_hit_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEPDOWN && hit_s_i) |=> (state_q == ST_NORMAL));
    p_rise_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEPDOWN && rise) |=> (state_q == ST_NORMAL));
endmodule

// File: rtl/vsm_mode_sel.sv
module vsm_mode_sel
    import vsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              lock_req_i,
    input  logic [MODE_W-1:0] cfg_i,
    output drive_t            drive_o
);
    drive_t drive_d;

    always_comb begin
        if (step_i) begin
            drive_d = DRIVE_STEP;
        end else begin
            drive_d           = DRIVE_RESET;
            drive_d.pwm       = wants_pwm(cfg_i, lock_req_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) drive_o <= DRIVE_RESET;
        else     drive_o <= drive_d;
    end

    p_force_pfm_r9: assert property (@(posedge clk) disable iff (rst)
        step_i |=> !drive_o.pwm);
    p_gates_step_r4: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (drive_o.rev_block && drive_o.mf_hold));
    p_gates_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> (!drive_o.rev_block && !drive_o.mf_hold));
    p_idle_mode_r2: assert property (@(posedge clk) disable iff (rst)
        (!step_i && (cfg_i == MODE_FORCE_PWM)) |=> drive_o.pwm);
endmodule

// File: rtl/vstep_mode_ctl.sv
module vstep_mode_ctl
    import vsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              level_sel_i,
    input  logic              clk_lock_req_i,
    input  logic [MODE_W-1:0] mode_cfg_i,
    input  logic              target_hit_i,
    output logic              pwm_o,
    output logic              rev_block_o,
    output logic              mf_hold_o
);
    logic [1:0] raw_in, sync_out;
    logic       step;
    drive_t     drive;

    assign raw_in = {level_sel_i, target_hit_i};

    vsm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (sync_out)
    );

    vsm_step_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .sel_s_i (sync_out[1]),
        .hit_s_i (sync_out[0]),
        .step_o  (step)
    );

    vsm_mode_sel u_sel (
        .clk        (clk),
        .rst        (rst),
        .step_i     (step),
        .lock_req_i (clk_lock_req_i),
        .cfg_i      (mode_cfg_i),
        .drive_o    (drive)
    );

    assign pwm_o       = drive.pwm;
    assign rev_block_o = drive.rev_block;
    assign mf_hold_o   = drive.mf_hold;

    p_reset_r1: assert property (@(posedge clk) rst |=> (!pwm_o && !rev_block_o && !mf_hold_o));
endmodule

// File: tb/vstep_mode_ctl_tb.sv
module vstep_mode_ctl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic       lock = 1'b0;
    logic [1:0] cfg = 2'b00;
    logic       hit = 1'b0;
    logic       pwm, rb, mh;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    typedef struct {
        logic  pwm;
        logic  rb;
        logic  mh;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #10 clk = ~clk;

    vstep_mode_ctl u_dut (
        .clk(clk), .rst(rst), .level_sel_i(sel), .clk_lock_req_i(lock),
        .mode_cfg_i(cfg), .target_hit_i(hit),
        .pwm_o(pwm), .rev_block_o(rb), .mf_hold_o(mh)
    );

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if ({pwm, rb, mh} !== {e.pwm, e.rb, e.mh}) begin
                    n_bad++;
                    $display("FAIL %s: actual pwm/rb/mh=%b%b%b expected %b%b%b",
                             e.tag, pwm, rb, mh, e.pwm, e.rb, e.mh);
                end
            end
        end
    end

    task automatic expect_out(input logic p, input logic r, input logic m, input string tag);
        exp_t e;
        e.pwm = p; e.rb = r; e.mh = m; e.tag = tag;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cfg = 2'b01; lock = 1'b1;
        step(3);
        expect_out(0, 0, 0, "R1 in reset");
        rst = 1'b0; cfg = 2'b00; lock = 1'b0;
        step(1);
        expect_out(0, 0, 0, "R1 after reset");

        // R2 idle selection
        cfg = 2'b01; step(1); expect_out(1, 0, 0, "R2 force pwm code");
        cfg = 2'b10; step(1); expect_out(0, 0, 0, "R2 auto code 10");
        cfg = 2'b00; lock = 1'b1; step(1); expect_out(1, 0, 0, "R2 lock request");
        lock = 1'b0; cfg = 2'b11; step(1); expect_out(0, 0, 0, "R2 auto code 11");

        // R7 rising select in idle
        cfg = 2'b01; sel = 1'b1;
        step(4); expect_out(1, 0, 0, "R7 rise no override");
        step(2); expect_out(1, 0, 0, "R7 still normal");

        // R3/R4/R5 falling select
        lock = 1'b1; sel = 1'b0;
        step(3); expect_out(1, 0, 0, "R3 not before fourth edge");
        step(1); expect_out(0, 1, 1, "R3 R4 R5 override active");

        // R9 config changes masked
        cfg = 2'b00; lock = 1'b0; step(1);
        cfg = 2'b01; lock = 1'b1;
        step(2); expect_out(0, 1, 1, "R9 config masked");

        // R6 target reached
        hit = 1'b1;
        step(3); expect_out(0, 1, 1, "R6 still override");
        step(1); expect_out(1, 0, 0, "R6 R9 back to config");
        hit = 1'b0;
        step(4); expect_out(1, 0, 0, "R6 stays normal");
        cfg = 2'b00; lock = 1'b0;
        step(1); expect_out(0, 0, 0, "R9 config applies after end");

        // R8 rise during override
        cfg = 2'b01;
        sel = 1'b1; step(4); expect_out(1, 0, 0, "R7 rise idle");
        sel = 1'b0; step(4); expect_out(0, 1, 1, "R8 override started");
        sel = 1'b1;
        step(3); expect_out(0, 1, 1, "R8 still override");
        step(1); expect_out(1, 0, 0, "R8 ended by rise");

        // R10 flag already high at fall
        hit = 1'b1; step(3);
        sel = 1'b0;
        step(4); expect_out(0, 1, 1, "R10 one-cycle override");
        step(1); expect_out(1, 0, 0, "R10 override over");
        hit = 1'b0;
        step(3); expect_out(1, 0, 0, "R10 stays normal");

        step(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule